// File: doc/BRIEF.md
# Decode Buffer Size Checker

This block validates one video-decode request against the smallest reference buffer that its codec needs. A request carries a stream type, the picture width and height, the reference buffer size declared by the request, and the pitch of the target surface. A one-cycle `start` pulse latches all of these. The block then computes the frame image size and a codec-specific minimum buffer size. It does this over several cycles with one shared 32-bit multiplier, so it never builds a wide tree of multipliers.

The minimum is built from these pieces:
- a number of whole images;
- macroblock products, where the width in macroblocks is the width divided by 16, and the height in macroblocks is the height divided by 16 and then rounded up to an even count;
- steps that round a value up to an alignment boundary.

When the computation ends, the block raises `done` for exactly one clock and reports a verdict. On success it also returns the sizes required for buffer slot 1 (the declared reference size) and buffer slot 2 (the image size). All arithmetic is unsigned and modulo 2^32.

The controller has five named states:
- IDLE waits for `start`. With a supported codec it goes to IMAGE. With any other codec it goes straight to CHECK.
- IMAGE multiplies width by height and forms the aligned image size, then goes to MBAREA.
- MBAREA multiplies the two macroblock counts, then goes to TERMS.
- TERMS adds one product term per cycle. It stays in TERMS until the codec's last term, then goes to CHECK.
- CHECK registers the verdict, raises `done` and returns to IDLE.

Top module: `dbuf_size_check`

## Requirements
- R1: The image size is I = roundup(P + P/2, 1024), where P = width*height. The width in macroblocks is wmb = width/16. The height in macroblocks is hmb = roundup(height/16, 2). Here roundup(x, n) is the smallest multiple of n that is not below x, and "/" is integer division.
- R2: For stream type 0, the minimum is 17*I + wmb*hmb*3264 + wmb*hmb*32.
- R3: For stream type 1, the minimum is 3*I + wmb*hmb*128 + wmb*64 + wmb*128 + roundup(max(wmb,hmb)*112, 64).
- R4: For stream type 3, the minimum is 3*I. For stream type 4, the minimum is 3*I + wmb*hmb*64 + roundup(wmb*hmb*32, 64).
- R5: Any stream type other than 0, 1, 3 or 4 fails with `err_code` 1. This error takes priority over all other errors.
- R6: With a supported type, a width greater than the pitch fails with `err_code` 2. A width equal to the pitch passes this check. This error takes priority over R7.
- R7: A declared size below the minimum fails with `err_code` 3. A declared size equal to the minimum passes.
- R8: When `done` is high, `pass` is 1 exactly when `err_code` is 0. On a pass, `ref_size_out` equals the declared size and `img_size_out` equals I. On a fail, both size outputs are 0.
- R9: `done` is a one-clock pulse. Counted in clock edges after the edge that accepts `start`, it arrives 6 edges later for type 0, 8 for type 1, 4 for type 3, 6 for type 4, and 1 for an unsupported type.
- R10: `busy` is high from the edge that accepts `start` until the edge that raises `done`, and it is low while `done` is high. A `start` seen while `busy` is high is ignored and does not change the result.
- R11: After reset, `busy`, `done`, `pass`, `err_code` and both size outputs are 0. The result outputs hold their values between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accepts a request when the block is idle |
| stream_type | input | 32 | Codec selector (0, 1, 3, 4 supported) |
| pic_width | input | 32 | Picture width in pixels |
| pic_height | input | 32 | Picture height in pixels |
| ref_buf_size | input | 32 | Declared reference buffer size in bytes |
| dst_pitch | input | 32 | Target surface pitch |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Request accepted |
| err_code | output | 2 | 0 none, 1 codec, 2 pitch, 3 buffer too small |
| ref_size_out | output | 32 | Required slot 1 size on pass, else 0 |
| img_size_out | output | 32 | Required slot 2 size on pass, else 0 |

## Verification
Two situations are hard to reach from the ports.

The first is a request whose declared size equals the computed minimum, or is one below it. The bench's model computes the exact minimum for each codec and each picture shape, then drives that value and that value minus one. This places the comparison exactly on its edge. One of these shapes has a height whose macroblock count is odd, so the minimum depends on the even rounding of hmb.

The second is a fresh `start`, carrying different operands, that arrives while a computation is running. The bench raises such a pulse in the middle of a type-0 request. It then checks that the reported sizes belong to the first request and that no second `done` follows.

// File: rtl/dbsc_pkg.sv
package dbsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IMAGE,
        ST_MBAREA,
        ST_TERMS,
        ST_CHECK
    } dbsc_state_e;

    typedef enum logic [1:0] {
        SRC_IMG,
        SRC_MBA,
        SRC_WMB,
        SRC_MAX
    } dbsc_src_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_CODEC = 2'd1,
        ERR_PITCH = 2'd2,
        ERR_SHORT = 2'd3
    } dbsc_err_e;

    // One summand of the minimum: operand source, constant factor,
    // whether the product is rounded up to the term alignment, last flag.
    typedef struct packed {
        dbsc_src_e   src;
        logic [11:0] k;
        logic        rnd;
        logic        last;
    } dbsc_term_t;

    function automatic logic codec_ok(input logic [31:0] c);
        return (c == 32'd0) || (c == 32'd1) || (c == 32'd3) || (c == 32'd4);
    endfunction

    function automatic dbsc_term_t term_of(input logic [31:0] c, input logic [2:0] i);
        dbsc_term_t t;
        t = '{src: SRC_IMG, k: 12'd3, rnd: 1'b0, last: 1'b1};
        if (c == 32'd0) begin
            case (i)
                3'd0:    t = '{src: SRC_IMG, k: 12'd17,   rnd: 1'b0, last: 1'b0};
                3'd1:    t = '{src: SRC_MBA, k: 12'd3264, rnd: 1'b0, last: 1'b0};
                default: t = '{src: SRC_MBA, k: 12'd32,   rnd: 1'b0, last: 1'b1};
            endcase
        end else if (c == 32'd1) begin
            case (i)
                3'd0:    t = '{src: SRC_IMG, k: 12'd3,   rnd: 1'b0, last: 1'b0};
                3'd1:    t = '{src: SRC_MBA, k: 12'd128, rnd: 1'b0, last: 1'b0};
                3'd2:    t = '{src: SRC_WMB, k: 12'd64,  rnd: 1'b0, last: 1'b0};
                3'd3:    t = '{src: SRC_WMB, k: 12'd128, rnd: 1'b0, last: 1'b0};
                default: t = '{src: SRC_MAX, k: 12'd112, rnd: 1'b1, last: 1'b1};
            endcase
        end else if (c == 32'd4) begin
            case (i)
                3'd0:    t = '{src: SRC_IMG, k: 12'd3,  rnd: 1'b0, last: 1'b0};
                3'd1:    t = '{src: SRC_MBA, k: 12'd64, rnd: 1'b0, last: 1'b0};
                default: t = '{src: SRC_MBA, k: 12'd32, rnd: 1'b1, last: 1'b1};
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/dbsc_mul.sv
module dbsc_mul #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] p
);
    // Low word of the product: all sizing arithmetic wraps modulo 2^DW.
    assign p = a * b;
endmodule

// File: rtl/dbsc_roundup.sv
module dbsc_roundup #(
    parameter int DW = 32,
    parameter int LG = 10
) (
    input  logic [DW-1:0] x,
    output logic [DW-1:0] y
);
    localparam logic [DW-1:0] MASK = (DW'(1) << LG) - DW'(1);
    assign y = (x + MASK) & ~MASK;
endmodule

// File: rtl/dbuf_size_check.sv
module dbuf_size_check
    import dbsc_pkg::*;
#(
    parameter int DW       = 32,
    parameter int MB_SHIFT = 4,
    parameter int HMB_LG   = 1,
    parameter int IMG_LG   = 10,
    parameter int TERM_LG  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] stream_type,
    input  logic [DW-1:0] pic_width,
    input  logic [DW-1:0] pic_height,
    input  logic [DW-1:0] ref_buf_size,
    input  logic [DW-1:0] dst_pitch,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic [1:0]    err_code,
    output logic [DW-1:0] ref_size_out,
    output logic [DW-1:0] img_size_out
);

    localparam int KW = 12;

    dbsc_state_e state_q, state_d;

    logic [DW-1:0] cod_q, w_q, h_q, dpb_q, pitch_q;
    logic [DW-1:0] wmb_q, hmb_q, img_q, mba_q, acc_q;
    logic [2:0]    idx_q;

    logic          done_q, pass_q;
    dbsc_err_e     err_q, chk_err;
    logic [DW-1:0] refo_q, imgo_q;

    logic [DW-1:0] mul_a, mul_b, prod;
    logic [DW-1:0] hmb_next, img_next, prod_rnd, half_sum, term_val, mb_max;
    dbsc_term_t    term;

    // ---------------- shared arithmetic ----------------
    dbsc_roundup #(.DW(DW), .LG(HMB_LG)) u_rnd_hmb (
        .x (pic_height >> MB_SHIFT),
        .y (hmb_next)
    );

    dbsc_mul #(.DW(DW)) u_mul (
        .a (mul_a),
        .b (mul_b),
        .p (prod)
    );

    assign half_sum = prod + (prod >> 1);

    dbsc_roundup #(.DW(DW), .LG(IMG_LG)) u_rnd_img (
        .x (half_sum),
        .y (img_next)
    );

    dbsc_roundup #(.DW(DW), .LG(TERM_LG)) u_rnd_term (
        .x (prod),
        .y (prod_rnd)
    );

    assign term     = term_of(cod_q, idx_q);
    assign mb_max   = (wmb_q > hmb_q) ? wmb_q : hmb_q;
    assign term_val = term.rnd ? prod_rnd : prod;

    always_comb begin
        mul_a = '0;
        mul_b = '0;
        unique case (state_q)
            ST_IMAGE: begin
                mul_a = w_q;
                mul_b = h_q;
            end
            ST_MBAREA: begin
                mul_a = wmb_q;
                mul_b = hmb_q;
            end
            ST_TERMS: begin
                unique case (term.src)
                    SRC_IMG: mul_a = img_q;
                    SRC_MBA: mul_a = mba_q;
                    SRC_WMB: mul_a = wmb_q;
                    SRC_MAX: mul_a = mb_max;
                    default: mul_a = '0;
                endcase
                mul_b = {{(DW-KW){1'b0}}, term.k};
            end
            default: begin
                mul_a = '0;
                mul_b = '0;
            end
        endcase
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = codec_ok(stream_type) ? ST_IMAGE : ST_CHECK;
            ST_IMAGE:  state_d = ST_MBAREA;
            ST_MBAREA: state_d = ST_TERMS;
            ST_TERMS:  if (term.last) state_d = ST_CHECK;
            ST_CHECK:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cod_q   <= '0;
            w_q     <= '0;
            h_q     <= '0;
            dpb_q   <= '0;
            pitch_q <= '0;
            wmb_q   <= '0;
            hmb_q   <= '0;
            img_q   <= '0;
            mba_q   <= '0;
            acc_q   <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    cod_q   <= stream_type;
                    w_q     <= pic_width;
                    h_q     <= pic_height;
                    dpb_q   <= ref_buf_size;
                    pitch_q <= dst_pitch;
                    wmb_q   <= pic_width >> MB_SHIFT;
                    hmb_q   <= hmb_next;
                    acc_q   <= '0;
                    idx_q   <= '0;
                end
                ST_IMAGE:  img_q <= img_next;
                ST_MBAREA: mba_q <= prod;
                ST_TERMS: begin
                    acc_q <= acc_q + term_val;
                    idx_q <= idx_q + 3'd1;
                end
                default: ;
            endcase
        end
    end

    // ---------------- verdict and outputs ----------------
    always_comb begin
        if (!codec_ok(cod_q))    chk_err = ERR_CODEC;
        else if (w_q > pitch_q)  chk_err = ERR_PITCH;
        else if (dpb_q < acc_q)  chk_err = ERR_SHORT;
        else                     chk_err = ERR_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            pass_q <= 1'b0;
            err_q  <= ERR_NONE;
            refo_q <= '0;
            imgo_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_CHECK) begin
                done_q <= 1'b1;
                err_q  <= chk_err;
                pass_q <= (chk_err == ERR_NONE);
                refo_q <= (chk_err == ERR_NONE) ? dpb_q : '0;
                imgo_q <= (chk_err == ERR_NONE) ? img_q : '0;
            end
        end
    end

    assign busy         = (state_q != ST_IDLE);
    assign done         = done_q;
    assign pass         = pass_q;
    assign err_code     = err_q;
    assign ref_size_out = refo_q;
    assign img_size_out = imgo_q;

    // ---------------- assertions ----------------
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R10
    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R10
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> $stable(w_q) && $stable(dpb_q)); // R10
    AST_PASS_SIZES: assert property (@(posedge clk) disable iff (!rst_n) (done && pass) |-> (err_code == 2'd0) && (ref_size_out == dpb_q)); // R8
    AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && !pass) |-> (err_code != 2'd0) && (ref_size_out == '0) && (img_size_out == '0)); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(pass) && $stable(err_code) && $stable(ref_size_out) && $stable(img_size_out)); // R11

endmodule

// File: tb/dbuf_size_check_test.sv
module dbuf_size_check_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] stream_type = '0, pic_width = '0, pic_height = '0;
    logic [31:0] ref_buf_size = '0, dst_pitch = '0;
    logic        busy, done, pass;
    logic [1:0]  err_code;
    logic [31:0] ref_size_out, img_size_out;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    int unsigned cycles = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    dbuf_size_check uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .stream_type(stream_type), .pic_width(pic_width), .pic_height(pic_height),
        .ref_buf_size(ref_buf_size), .dst_pitch(dst_pitch),
        .busy(busy), .done(done), .pass(pass), .err_code(err_code),
        .ref_size_out(ref_size_out), .img_size_out(img_size_out)
    );

    function automatic int unsigned al(input int unsigned x, input int unsigned n);
        return (x + n - 1) & ~(n - 1);
    endfunction

    function automatic int unsigned img_of(input int unsigned w, input int unsigned h);
        int unsigned p = w * h;
        return al(p + p / 2, 1024);
    endfunction

    function automatic int unsigned min_of(input int unsigned c, input int unsigned w, input int unsigned h);
        int unsigned wmb = w / 16;
        int unsigned hmb = al(h / 16, 2);
        int unsigned mba = wmb * hmb;
        int unsigned im  = img_of(w, h);
        int unsigned mx  = (wmb > hmb) ? wmb : hmb;
        case (c)
            0: return im * 17 + mba * 17 * 192 + mba * 32;
            1: return im * 3 + mba * 128 + wmb * 64 + wmb * 128 + al(mx * 7 * 16, 64);
            3: return im * 3;
            4: return im * 3 + mba * 64 + al(mba * 32, 64);
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one request and compare every cycle against the model.
    task automatic run_req(input int unsigned c, input int unsigned w, input int unsigned h,
                           input int unsigned d, input int unsigned p,
                           input string req, input bit spur);
        int unsigned e_err, e_img, e_ref, lat, mn;
        bit e_pass;
        if (!(c == 0 || c == 1 || c == 3 || c == 4)) begin
            e_err = 1; lat = 1;
        end else begin
            mn = min_of(c, w, h);
            lat = (c == 1) ? 8 : (c == 3) ? 4 : 6;
            if (w > p)       e_err = 2;
            else if (d < mn) e_err = 3;
            else             e_err = 0;
        end
        e_pass = (e_err == 0);
        e_ref  = e_pass ? d : 0;
        e_img  = e_pass ? img_of(w, h) : 0;

        @(negedge clk);
        stream_type = c; pic_width = w; pic_height = h; ref_buf_size = d; dst_pitch = p;
        start = 1'b1;
        for (int n = 1; n <= int'(lat) + 2; n++) begin
            @(negedge clk);
            if (spur && n < 3) begin
                start = 1'b1;
                pic_width = 32'd16; ref_buf_size = 32'd0; dst_pitch = 32'd8;
            end else begin
                start = 1'b0;
            end
            if (n <= int'(lat) + 1)
                chk(busy == (n <= int'(lat)), "R10", "busy", busy, n <= int'(lat));
            chk(done == (n == int'(lat) + 1), "R9", "done", done, n == int'(lat) + 1);
            if (n >= int'(lat) + 1) begin
                // n == lat+1: result cycle; n == lat+2: held (R11)
                chk(err_code == e_err[1:0], (n > int'(lat) + 1) ? "R11" : req, "err_code", err_code, e_err);
                chk(pass == e_pass, "R8", "pass", pass, e_pass);
                chk(ref_size_out == e_ref, "R8", "ref_size_out", ref_size_out, e_ref);
                chk(img_size_out == e_img, req, "img_size_out", img_size_out, e_img);
            end
        end
    endtask

    initial begin : watchdog
        while (cycles < 20000 && !finished) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(busy == 0 && done == 0, "R11", "busy/done at reset", {busy, done}, 0);
        chk(pass == 0 && err_code == 0, "R11", "pass/err at reset", {pass, err_code}, 0);
        chk(ref_size_out == 0 && img_size_out == 0, "R11", "sizes at reset", ref_size_out | img_size_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 main path, with a start pulse mid-run that must be ignored (R10)
        run_req(0, 1920, 1080, 32'h1000_0000, 2048, "R2", 1'b1);
        run_req(0, 1920, 1080, min_of(0, 1920, 1080), 1920, "R7", 1'b0);
        run_req(0, 1920, 1080, min_of(0, 1920, 1080) - 1, 1920, "R7", 1'b0);
        // R1 odd macroblock height rounds up to even
        run_req(0, 32, 50, min_of(0, 32, 50), 32, "R1", 1'b0);
        run_req(0, 32, 50, min_of(0, 32, 50) - 1, 32, "R1", 1'b0);
        // R3 both orientations of the max term
        run_req(1, 720, 480, 32'h0400_0000, 720, "R3", 1'b0);
        run_req(1, 64, 1000, min_of(1, 64, 1000), 64, "R3", 1'b0);
        run_req(1, 64, 1000, min_of(1, 64, 1000) - 1, 64, "R3", 1'b0);
        // R4
        run_req(3, 352, 288, min_of(3, 352, 288), 352, "R4", 1'b0);
        run_req(4, 176, 144, min_of(4, 176, 144), 176, "R4", 1'b0);
        run_req(4, 176, 144, min_of(4, 176, 144) - 1, 176, "R7", 1'b0);
        // R5 unsupported codec, priority over pitch
        run_req(2, 352, 288, 32'h0100_0000, 352, "R5", 1'b0);
        run_req(7, 352, 288, 0, 16, "R5", 1'b0);
        // R6 pitch, priority over short buffer; equal pitch passes
        run_req(0, 352, 288, 0, 351, "R6", 1'b0);
        run_req(3, 352, 288, 32'h0100_0000, 352, "R6", 1'b0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule